// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error tallies of a CAN node, one for receive errors and one for transmit errors, and derives the node's fault confinement state from them. It has no knowledge of frames. A bit stream processor decides which errors have happened and sends single-cycle command pulses. Each increment pulse adds either a small step of 1 or a large step of 8 to one tally. Each decrement pulse removes 1. The block turns the tallies into one of three states: error active, error passive or bus-off.

Bus-off starts when the transmit tally goes past 255. From then on the tallies are frozen and every command is ignored. To leave bus-off, software first raises a recovery request. After that, the bit stream processor must report 128 sequences of 11 consecutive recessive bits, one pulse per sequence. When the last sequence arrives, both tallies return to zero and the node is error active again. Both tallies can be read at all times.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both tallies read 0 and the state output reads 0 (error active).
- R2: Outside bus-off, an increment pulse adds 8 to its tally when its large-step input is high and 1 otherwise. A tally changes only on a command pulse or on recovery.
- R3: A decrement pulse lowers its tally by 1. A decrement of a tally that is already 0 leaves it at 0.
- R4: When increment and decrement pulses for the same tally arrive in the same cycle, the increment is applied and the decrement is dropped.
- R5: Outside bus-off, the state output reads 1 (error passive) when either tally is at least 128, and 0 (error active) when both are below 128.
- R6: The receive tally never goes above 255. An increment that would pass 255 leaves it at 255.
- R7: When an increment takes the transmit tally past 255, the tally shows the new value (256 to 263) in the next cycle and the state output reads 2 (bus-off) in that same cycle.
- R8: In bus-off, increment and decrement pulses on either tally have no effect, and both tallies hold their values.
- R9: In bus-off, a recovery request arms the recovery. Only sequence pulses that arrive in cycles after arming are counted; a pulse in the arming cycle itself is not counted. On the 128th counted pulse, the next cycle shows state 0 with both tallies at 0. Sequence pulses that arrive before arming are ignored.
- R10: Outside bus-off, recovery requests and sequence pulses have no effect on the tallies or on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_inc | input | 1 | Receive tally increment pulse |
| rx_big | input | 1 | Large step (8) for rx_inc |
| rx_dec | input | 1 | Receive tally decrement pulse |
| tx_inc | input | 1 | Transmit tally increment pulse |
| tx_big | input | 1 | Large step (8) for tx_inc |
| tx_dec | input | 1 | Transmit tally decrement pulse |
| recover_req | input | 1 | Bus-off recovery request |
| idle_seq | input | 1 | One sequence of 11 recessive bits seen |
| rx_count | output | 9 | Receive error tally |
| tx_count | output | 9 | Transmit error tally |
| fc_state | output | 2 | 0 error active, 1 error passive, 2 bus-off |

## Verification
The assertions check four things on every cycle. The receive tally never passes its ceiling. A tally with no command either holds its value or, at zero, stays at zero. Bus-off begins only after a transmit increment. While in bus-off, the tallies are either frozen or cleared together with the return to error active. Other behaviour can only be shown by the bench's scenarios. These scenarios cover the exact step sizes and the increment-over-decrement priority, the passive threshold in both directions, and the value the transmit tally shows when it crosses. They also cover the count of exactly 128 sequences after arming, including pulses that arrive before the request and in the arming cycle, and the absence of any effect from recovery inputs outside bus-off.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
   typedef enum logic [1:0] {
      FC_ACTIVE  = 2'd0,
      FC_PASSIVE = 2'd1,
      FC_BUSOFF  = 2'd2
   } fc_state_e;
endpackage

// File: rtl/can_fc_counter.sv
module can_fc_counter #(
   parameter int unsigned W        = 9,
   parameter int unsigned BIG_STEP = 8,
   parameter int unsigned CEIL     = 255,
   parameter bit          SAT      = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         big,
   input  logic         dec,
   input  logic         hold,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam int unsigned XW = W + 1;

   generate
      if (CEIL >= (1 << W)) begin : g_bad_ceil
         $error("ceiling does not fit the tally width");
      end
   endgenerate

   logic [XW-1:0] sum;
   logic [W-1:0]  up;

   assign sum = {1'b0, cnt} + (big ? XW'(BIG_STEP) : XW'(1));

   generate
      if (SAT) begin : g_sat
         always_comb up = (sum > XW'(CEIL)) ? W'(CEIL) : sum[W-1:0];
      end else begin : g_free
         always_comb up = sum[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (!hold) begin
         if (inc)
            cnt <= up;
         else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
   parameter int unsigned RECOV_SEQS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busoff,
   input  logic recover_req,
   input  logic idle_seq,
   output logic done
);
   localparam int unsigned SW = (RECOV_SEQS > 2) ? $clog2(RECOV_SEQS) : 1;

   generate
      if (RECOV_SEQS < 2) begin : g_bad_seqs
         $error("recovery needs at least two sequences");
      end
   endgenerate

   logic          armed;
   logic [SW-1:0] seen;

   assign done = busoff && armed && idle_seq && (seen == SW'(RECOV_SEQS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         seen  <= '0;
      end else if (!busoff || done) begin
         armed <= 1'b0;
         seen  <= '0;
      end else if (!armed) begin
         armed <= recover_req;
      end else if (idle_seq) begin
         seen <= seen + 1'b1;
      end
   end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
   import can_fc_pkg::*;
#(
   parameter int unsigned CNT_W        = 9,
   parameter int unsigned BIG_STEP     = 8,
   parameter int unsigned PASSIVE_TH   = 128,
   parameter int unsigned BUSOFF_LIMIT = 255,
   parameter int unsigned RX_CEIL      = 255,
   parameter int unsigned RECOV_SEQS   = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_inc,
   input  logic             rx_big,
   input  logic             rx_dec,
   input  logic             tx_inc,
   input  logic             tx_big,
   input  logic             tx_dec,
   input  logic             recover_req,
   input  logic             idle_seq,
   output logic [CNT_W-1:0] rx_count,
   output logic [CNT_W-1:0] tx_count,
   output logic [1:0]       fc_state
);
   generate
      if (BUSOFF_LIMIT + BIG_STEP >= (1 << CNT_W)) begin : g_bad_width
         $error("transmit tally cannot hold the bus-off crossing value");
      end
      if (PASSIVE_TH > BUSOFF_LIMIT) begin : g_bad_th
         $error("passive threshold above bus-off limit");
      end
   endgenerate

   logic      busoff;
   logic      recov_done;
   fc_state_e st;

   assign busoff = tx_count > CNT_W'(BUSOFF_LIMIT);

   can_fc_counter #(
      .W(CNT_W), .BIG_STEP(BIG_STEP), .CEIL(RX_CEIL), .SAT(1'b1)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .inc(rx_inc), .big(rx_big), .dec(rx_dec),
      .hold(busoff), .clr(recov_done), .cnt(rx_count)
   );

   can_fc_counter #(
      .W(CNT_W), .BIG_STEP(BIG_STEP), .CEIL((1 << CNT_W) - 1), .SAT(1'b0)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .inc(tx_inc), .big(tx_big), .dec(tx_dec),
      .hold(busoff), .clr(recov_done), .cnt(tx_count)
   );

   can_fc_recovery #(.RECOV_SEQS(RECOV_SEQS)) u_recov (
      .clk(clk), .rst_n(rst_n), .busoff(busoff), .recover_req(recover_req),
      .idle_seq(idle_seq), .done(recov_done)
   );

   always_comb begin
      if (busoff)
         st = FC_BUSOFF;
      else if (rx_count >= CNT_W'(PASSIVE_TH) || tx_count >= CNT_W'(PASSIVE_TH))
         st = FC_PASSIVE;
      else
         st = FC_ACTIVE;
   end

   assign fc_state = st;
endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
   parameter int unsigned W       = 9,
   parameter int unsigned RX_CEIL = 255
) (
   input logic         clk,
   input logic         rst_n,
   input logic         rx_inc,
   input logic         rx_dec,
   input logic         tx_inc,
   input logic [W-1:0] rx_count,
   input logic [W-1:0] tx_count,
   input logic [1:0]   fc_state
);
   // R6
   rx_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= W'(RX_CEIL));

   // R2
   rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state != 2'd2 && !rx_inc && !rx_dec) |=> rx_count == $past(rx_count));

   // R3
   rx_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == '0 && !rx_inc) |=> rx_count == '0);

   // R7
   busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state != 2'd2) |=> (fc_state != 2'd2 || $past(tx_inc)));

   // R8
   busoff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_state == 2'd2) |=>
         ((fc_state == 2'd2 && $stable(tx_count) && $stable(rx_count)) ||
          (fc_state == 2'd0 && tx_count == '0 && rx_count == '0)));
endmodule

bind can_fault_conf can_fc_checker #(.W(CNT_W), .RX_CEIL(RX_CEIL)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_inc(rx_inc), .rx_dec(rx_dec), .tx_inc(tx_inc),
   .rx_count(rx_count), .tx_count(tx_count), .fc_state(fc_state)
);

// File: tb/sim_can_fault_conf.sv
`timescale 1ns/1ps
module sim_can_fault_conf;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_inc = 0, rx_big = 0, rx_dec = 0, tx_inc = 0, tx_big = 0, tx_dec = 0;
   logic recover_req = 0, idle_seq = 0;
   logic [8:0] rx_count, tx_count;
   logic [1:0] fc_state;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   int m_rx = 0, m_tx = 0, m_seen = 0;
   bit m_armed = 0;

   always #2.5 clk = ~clk;

   can_fault_conf u0 (
      .clk(clk), .rst_n(rst_n), .rx_inc(rx_inc), .rx_big(rx_big), .rx_dec(rx_dec),
      .tx_inc(tx_inc), .tx_big(tx_big), .tx_dec(tx_dec), .recover_req(recover_req),
      .idle_seq(idle_seq), .rx_count(rx_count), .tx_count(tx_count), .fc_state(fc_state)
   );

   function automatic int exp_state();
      if (m_tx > 255) return 2;
      if (m_rx >= 128 || m_tx >= 128) return 1;
      return 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_cmp();
      chk("model rx_count", int'(rx_count), m_rx);
      chk("model tx_count", int'(tx_count), m_tx);
      chk("model fc_state", int'(fc_state), exp_state());
   endtask

   // drive one cycle of inputs at a falling edge, update model at the rising edge
   task automatic cyc(bit ri, bit rb, bit rd, bit ti, bit tb, bit td, bit rq, bit id);
      bit was_armed;
      rx_inc = ri; rx_big = rb; rx_dec = rd;
      tx_inc = ti; tx_big = tb; tx_dec = td;
      recover_req = rq; idle_seq = id;
      @(posedge clk);
      if (m_tx > 255) begin
         was_armed = m_armed;
         if (was_armed && id) begin
            m_seen++;
            if (m_seen == 128) begin
               m_rx = 0; m_tx = 0; m_armed = 0; m_seen = 0;
            end
         end
         if (!was_armed && rq) m_armed = 1;
      end else begin
         if (ri) begin
            m_rx = m_rx + (rb ? 8 : 1);
            if (m_rx > 255) m_rx = 255;
         end else if (rd && m_rx > 0) m_rx--;
         if (ti) m_tx = m_tx + (tb ? 8 : 1);
         else if (td && m_tx > 0) m_tx--;
      end
      @(negedge clk);
      model_cmp();
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1;
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rx_count", int'(rx_count), 0);
      chk("R1 tx_count", int'(tx_count), 0);
      chk("R1 fc_state", int'(fc_state), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 step sizes
      cyc(1,0,0, 0,0,0, 0,0);
      chk("R2 rx small step", int'(rx_count), 1);
      cyc(1,1,0, 1,1,0, 0,0);
      chk("R2 rx large step", int'(rx_count), 9);
      chk("R2 tx large step", int'(tx_count), 8);
      repeat (3) cyc(0,0,0, 0,0,0, 0,0);
      chk("R2 rx holds without command", int'(rx_count), 9);

      // R3 decrement and floor
      repeat (10) cyc(0,0,1, 0,0,1, 0,0);
      chk("R3 rx floor", int'(rx_count), 0);
      chk("R3 tx floor", int'(tx_count), 0);

      // R4 increment wins
      cyc(1,0,1, 1,1,1, 0,0);
      chk("R4 rx inc over dec", int'(rx_count), 1);
      chk("R4 tx inc over dec", int'(tx_count), 8);

      // R5 passive threshold on rx
      repeat (15) cyc(1,1,0, 0,0,0, 0,0);
      chk("R5 rx at 121 active", int'(fc_state), 0);
      repeat (7) cyc(1,0,0, 0,0,0, 0,0);
      chk("R5 rx at 128 passive", int'(fc_state), 1);
      cyc(0,0,1, 0,0,0, 0,0);
      chk("R5 rx at 127 active", int'(fc_state), 0);

      // R6 rx ceiling
      repeat (20) cyc(1,1,0, 0,0,0, 0,0);
      chk("R6 rx saturates", int'(rx_count), 255);
      chk("R5 passive while saturated", int'(fc_state), 1);
      repeat (200) cyc(0,0,1, 0,0,0, 0,0);

      // R7 bus-off entry: tx 8 -> 256
      repeat (30) cyc(0,0,0, 1,1,0, 0,0);
      chk("R7 tx 248 passive", int'(fc_state), 1);
      cyc(0,0,0, 1,1,0, 0,0);
      chk("R7 crossing value", int'(tx_count), 256);
      chk("R7 bus-off state", int'(fc_state), 2);

      // R8 commands ignored
      cyc(1,1,0, 1,1,0, 0,0);
      cyc(0,0,1, 0,0,1, 0,0);
      chk("R8 rx frozen", int'(rx_count), m_rx);
      chk("R8 tx frozen", int'(tx_count), 256);
      chk("R8 still bus-off", int'(fc_state), 2);

      // R9 recovery count
      repeat (5) cyc(0,0,0, 0,0,0, 0,1);
      cyc(0,0,0, 0,0,0, 1,1);
      repeat (127) cyc(0,0,0, 0,0,0, 0,1);
      chk("R9 127 sequences not enough", int'(fc_state), 2);
      cyc(0,0,0, 0,0,0, 0,1);
      chk("R9 recovered state", int'(fc_state), 0);
      chk("R9 rx cleared", int'(rx_count), 0);
      chk("R9 tx cleared", int'(tx_count), 0);

      // R10 recovery inputs outside bus-off
      repeat (3) cyc(1,0,0, 0,0,0, 0,0);
      cyc(0,0,0, 0,0,0, 1,0);
      repeat (130) cyc(0,0,0, 0,0,0, 0,1);
      chk("R10 rx untouched", int'(rx_count), 3);
      chk("R10 state untouched", int'(fc_state), 0);

      // random traffic against the model
      for (int i = 0; i < 6000; i++) begin
         cyc($urandom_range(0,3) == 0, $urandom_range(0,3) == 0, $urandom_range(0,2) == 0,
             $urandom_range(0,2) == 0, $urandom_range(0,2) == 0, $urandom_range(0,4) == 0,
             $urandom_range(0,30) == 0, $urandom_range(0,1) == 0);
      end

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule